// File: doc/BRIEF.md
# Software-Clocked PHY Management Responder

This block answers PHY management frames that host software produces by writing a control word one bit at a time. Each host write carries three control bits: a management clock bit, a data bit from the host, and a read-mode bit that turns the data line around. The responder keeps the last written clock bit. It acts only when a write takes that bit from 0 to 1. On each such edge it shifts the host data bit into a 32-bit shift word and advances a bit counter. It decodes a read header after 16 bits and a write frame after 32 bits. During the read data phase it presents response bits on its `mdi` output.

The responder holds a bank of 32 management registers, each 16 bits wide, for a single PHY address. Every register has a fixed write mask: a write changes only the masked bits, and some registers cannot be written at all. A run of 32 one bits (preamble) brings the counter back to zero, so the host can recover frame alignment at any time. `mdi` is driven only by the responder, so host writes can never overwrite it.

Top module: `mii_mgmt_responder`

## Requirements
- R1: A host write counts as a rising edge only when its clock bit is 1 and the clock bit of the previous host write was 0. The clock bit is 0 after reset. Any other host write leaves the counter, the shift word, the registers and `mdi` unchanged.
- R2: On each rising edge the counter increments and the shift word shifts left by one. The host data bit enters at bit 0 when the incremented count is below 16 or read mode is clear. Otherwise a 0 enters.
- R3: While read mode is set and the count has reached 16, the host data bit is not shifted in. A continued read therefore shows 0 on `mdi` from the 33rd edge onward, even if the host data bit is 1.
- R4: When a shift leaves the shift word all ones, the counter returns to 0. A partial frame followed by a 32-bit preamble leaves the next frame correctly aligned.
- R5: At a count of 16, the shift word fields are decoded as follows: bits 15:12 are the opcode, bits 11:7 the PHY address and bits 6:2 the register number. Opcode 4'b0110 loads the register value into the shift word. On every edge at a count of 16 or more in read mode, `mdi` takes bit 15 of the shifted word. It holds its value at all other times. Edges 17 to 31 therefore present register bits 14 down to 0.
- R6: Only PHY address 1 responds. A read from any other address returns 0. A write to any other address changes no register.
- R7: At a count of 32, the shift word fields are decoded as follows: bits 31:28 are the opcode, bits 27:23 the PHY address, bits 22:18 the register number and bits 15:0 the data. Opcode 4'b0101 writes the data through the register's mask. The writable masks are:
  - 0xFFFF for registers 1, 2, 3, 5, 6 and 18 to 25
  - 0xC01F for register 4
  - 0x0FFF for register 16
  - 0 for all other registers, including register 0
- R8: After reset, `mdi` is 0 and the registers hold the following values. All other registers hold 0.

  | Register | Reset value |
  |---|---|
  | 0 | 0x3100 |
  | 1 | 0xF02C |
  | 2 | 0x7810 |
  | 4 | 0x0501 |
  | 5 | 0x4181 |
  | 16 | 0x0003 |
  | 18 | 0x0001 |
- R9: A frame whose opcode is neither the read nor the write code changes no register. The counter keeps running until the next preamble.
- R10: The counter saturates at 2^CNT_W-1 (63 by default). A saturated counter never reaches a decode count again until a preamble clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host writes the control bits this cycle |
| host_mdc | input | 1 | Written management clock bit |
| host_mdo | input | 1 | Written host data bit |
| host_rd_mode | input | 1 | Written read-mode (turnaround) bit |
| mdi | output | 1 | Response data bit owned by the responder |

## Verification
The hardest situation to reach is the saturated counter. It must stay stuck past the point where a wrapping counter would realign with a write frame. The stimulus sends a preamble, then exactly 64 zero edges, then a complete write frame with no preamble in front. A wrapping counter would accept that frame, while a saturating one leaves the register untouched. Read-mode gating is also hidden, because inserted bits only reach bit 15 late. It is exposed by clocking a read past its 32nd edge with the host data bit held at 1.

// File: rtl/mii_resp_pkg.sv
package mii_resp_pkg;

    localparam int WORD_W   = 32;
    localparam int DATA_W   = 16;
    localparam int REG_N    = 32;
    localparam int REG_AW   = 5;
    localparam int PHY_AW   = 5;
    localparam int READ_AT  = 16;
    localparam int WRITE_AT = 32;

    localparam logic [3:0] OP_READ  = 4'b0110;
    localparam logic [3:0] OP_WRITE = 4'b0101;

    typedef struct packed {
        logic [3:0]        op;
        logic [PHY_AW-1:0] phy;
        logic [REG_AW-1:0] reg_a;
    } mii_hdr_t;

    typedef enum logic [1:0] {
        ACT_IDLE,
        ACT_RESYNC,
        ACT_LOAD,
        ACT_STORE
    } mii_act_t;

    function automatic mii_hdr_t hdr_short(input logic [WORD_W-1:0] w);
        mii_hdr_t h;
        h.op    = w[15:12];
        h.phy   = w[11:7];
        h.reg_a = w[6:2];
        return h;
    endfunction

    function automatic mii_hdr_t hdr_long(input logic [WORD_W-1:0] w);
        mii_hdr_t h;
        h.op    = w[31:28];
        h.phy   = w[27:23];
        h.reg_a = w[22:18];
        return h;
    endfunction

    function automatic logic [DATA_W-1:0] reg_reset(input int idx);
        case (idx)
            0:       return 16'h3100;
            1:       return 16'hF02C;
            2:       return 16'h7810;
            4:       return 16'h0501;
            5:       return 16'h4181;
            16:      return 16'h0003;
            18:      return 16'h0001;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] reg_mask(input int idx);
        if (idx == 4)
            return 16'hC01F;
        else if (idx == 16)
            return 16'h0FFF;
        else if ((idx >= 1 && idx <= 6) || (idx >= 18 && idx <= 25))
            return 16'hFFFF;
        else
            return 16'h0000;
    endfunction

endpackage

// File: rtl/mii_clk_edge.sv
module mii_clk_edge (
    input  logic clk,
    input  logic rst,
    input  logic host_wr,
    input  logic mdc_in,
    output logic rise
);
    logic mdc_q;

    always_ff @(posedge clk) begin
        if (rst)
            mdc_q <= 1'b0;
        else if (host_wr)
            mdc_q <= mdc_in;
    end

    assign rise = host_wr & mdc_in & ~mdc_q;
endmodule

// File: rtl/mii_reg_bank.sv
module mii_reg_bank
    import mii_resp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [REG_AW-1:0] rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] reg0
);
    logic [DATA_W-1:0] bank_q [REG_N];

    for (genvar i = 0; i < REG_N; i++) begin : g_reg
        localparam logic [DATA_W-1:0] MASK = reg_mask(i);
        localparam logic [DATA_W-1:0] INIT = reg_reset(i);

        always_ff @(posedge clk) begin
            if (rst)
                bank_q[i] <= INIT;
            else if (wr_en && wr_idx == REG_AW'(i))
                bank_q[i] <= (bank_q[i] & ~MASK) | (wr_data & MASK);
        end
    end

    assign rd_data = bank_q[rd_idx];
    assign reg0    = bank_q[0];
endmodule

// File: rtl/mii_frame_engine.sv
module mii_frame_engine
    import mii_resp_pkg::*;
#(
    parameter int          CNT_W    = 6,
    parameter logic [4:0]  PHY_ADDR = 5'd1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rise,
    input  logic              mdo,
    input  logic              rd_mode,
    input  logic [DATA_W-1:0] rd_data,
    output logic [REG_AW-1:0] rd_idx,
    output logic              wr_en,
    output logic [REG_AW-1:0] wr_idx,
    output logic [DATA_W-1:0] wr_data,
    output logic              mdi,
    output logic [CNT_W-1:0]  cnt_q,
    output logic [WORD_W-1:0] word_q
);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] CNT_RD   = CNT_W'(READ_AT);
    localparam logic [CNT_W-1:0] CNT_WR   = CNT_W'(WRITE_AT);

    logic [CNT_W-1:0]  cnt_inc;
    logic              ins_bit;
    logic [WORD_W-1:0] word_sh;
    mii_hdr_t          hdr_s;
    mii_hdr_t          hdr_l;
    mii_act_t          act;
    logic [DATA_W-1:0] load_val;
    logic              mdi_q;

    always_comb begin
        cnt_inc = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
        ins_bit = mdo && ((cnt_inc < CNT_RD) || !rd_mode);
        word_sh = {word_q[WORD_W-2:0], ins_bit};
        hdr_s   = hdr_short(word_sh);
        hdr_l   = hdr_long(word_sh);

        if (word_sh == '1)
            act = ACT_RESYNC;
        else if (cnt_inc == CNT_RD && hdr_s.op == OP_READ)
            act = ACT_LOAD;
        else if (cnt_inc == CNT_WR && hdr_l.op == OP_WRITE && hdr_l.phy == PHY_ADDR)
            act = ACT_STORE;
        else
            act = ACT_IDLE;

        load_val = (hdr_s.phy == PHY_ADDR) ? rd_data : '0;
    end

    assign rd_idx  = hdr_s.reg_a;
    assign wr_en   = rise && (act == ACT_STORE);
    assign wr_idx  = hdr_l.reg_a;
    assign wr_data = word_sh[DATA_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            word_q <= '0;
            mdi_q  <= 1'b0;
        end else if (rise) begin
            cnt_q  <= (act == ACT_RESYNC) ? '0 : cnt_inc;
            word_q <= (act == ACT_LOAD) ? {{(WORD_W-DATA_W){1'b0}}, load_val} : word_sh;
            if (cnt_inc >= CNT_RD && rd_mode)
                mdi_q <= word_sh[DATA_W-1];
        end
    end

    assign mdi = mdi_q;
endmodule

// File: rtl/mii_mgmt_responder.sv
module mii_mgmt_responder
    import mii_resp_pkg::*;
#(
    parameter int         CNT_W    = 6,
    parameter logic [4:0] PHY_ADDR = 5'd1
) (
    input  logic clk,
    input  logic rst,
    input  logic host_wr,
    input  logic host_mdc,
    input  logic host_mdo,
    input  logic host_rd_mode,
    output logic mdi
);
    logic              edge_rise;
    logic [REG_AW-1:0] rd_idx;
    logic [DATA_W-1:0] rd_data;
    logic              wr_en;
    logic [REG_AW-1:0] wr_idx;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] reg0_val;
    logic [CNT_W-1:0]  bit_cnt;
    logic [WORD_W-1:0] shift_word;

    mii_clk_edge u_edge (
        .clk     (clk),
        .rst     (rst),
        .host_wr (host_wr),
        .mdc_in  (host_mdc),
        .rise    (edge_rise)
    );

    mii_frame_engine #(
        .CNT_W    (CNT_W),
        .PHY_ADDR (PHY_ADDR)
    ) u_engine (
        .clk     (clk),
        .rst     (rst),
        .rise    (edge_rise),
        .mdo     (host_mdo),
        .rd_mode (host_rd_mode),
        .rd_data (rd_data),
        .rd_idx  (rd_idx),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .mdi     (mdi),
        .cnt_q   (bit_cnt),
        .word_q  (shift_word)
    );

    mii_reg_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (rd_idx),
        .rd_data (rd_data),
        .reg0    (reg0_val)
    );
endmodule

// File: rtl/mii_resp_chk.sv
module mii_resp_chk #(
    parameter int CNT_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             rise,
    input logic             rd_mode,
    input logic             mdi,
    input logic [CNT_W-1:0] cnt_q,
    input logic [31:0]      word_q,
    input logic [15:0]      reg0
);
    localparam logic [CNT_W-1:0] CMAX = '1;

    p_mdi_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !rise |=> $stable(mdi));

    p_cnt_step_r2: assert property (@(posedge clk) disable iff (rst)
        (rise && cnt_q != CMAX) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1) || cnt_q == '0));

    p_rd_no_insert_r3: assert property (@(posedge clk) disable iff (rst)
        (rise && rd_mode && cnt_q >= CNT_W'(16)) |=> (word_q[0] == 1'b0));

    p_preamble_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (word_q == 32'hFFFF_FFFF) |-> (cnt_q == '0));

    p_reg0_fixed_r7: assert property (@(posedge clk) disable iff (rst)
        reg0 == 16'h3100);

    p_cnt_sat_r10: assert property (@(posedge clk) disable iff (rst)
        (rise && cnt_q == CMAX) |=> (cnt_q == CMAX || cnt_q == '0));
endmodule

bind mii_mgmt_responder mii_resp_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .rise    (edge_rise),
    .rd_mode (host_rd_mode),
    .mdi     (mdi),
    .cnt_q   (bit_cnt),
    .word_q  (shift_word),
    .reg0    (reg0_val)
);

// File: tb/mii_mgmt_responder_tb.sv
module mii_mgmt_responder_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic host_wr = 1'b0;
    logic h_mdc = 1'b0;
    logic h_mdo = 1'b0;
    logic h_rd = 1'b0;
    logic mdi;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam int SAT = 63;

    always #4 clk = ~clk;

    mii_mgmt_responder u_dut (
        .clk          (clk),
        .rst          (rst),
        .host_wr      (host_wr),
        .host_mdc     (h_mdc),
        .host_mdo     (h_mdo),
        .host_rd_mode (h_rd),
        .mdi          (mdi)
    );

    // Behavioural reference model
    int          m_cnt;
    logic [31:0] m_word;
    logic        m_mdi;
    logic        m_mdc;
    logic [15:0] m_reg [32];

    function automatic logic [15:0] spec_init(input int i);
        case (i)
            0: return 16'h3100;  1: return 16'hF02C;  2: return 16'h7810;
            4: return 16'h0501;  5: return 16'h4181; 16: return 16'h0003;
            18: return 16'h0001;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic logic [15:0] spec_mask(input int i);
        if (i == 4) return 16'hC01F;
        if (i == 16) return 16'h0FFF;
        if ((i >= 1 && i <= 6) || (i >= 18 && i <= 25)) return 16'hFFFF;
        return 16'h0000;
    endfunction

    task automatic model_edge();
        int   n;
        int   r;
        logic b;
        n = (m_cnt == SAT) ? SAT : m_cnt + 1;
        b = h_mdo && (n < 16 || !h_rd);
        m_word = {m_word[30:0], b};
        if (n >= 16 && h_rd) m_mdi = m_word[15];
        if (m_word == 32'hFFFF_FFFF) begin
            n = 0;
        end else if (n == 16) begin
            if (m_word[15:12] == 4'd6)
                m_word = (m_word[11:7] == 5'd1) ? {16'h0, m_reg[m_word[6:2]]} : 32'h0;
        end else if (n == 32) begin
            if (m_word[31:28] == 4'd5 && m_word[27:23] == 5'd1) begin
                r = int'(m_word[22:18]);
                m_reg[r] = (m_reg[r] & ~spec_mask(r)) | (m_word[15:0] & spec_mask(r));
            end
        end
        m_cnt = n;
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_word = '0; m_mdi = 1'b0; m_mdc = 1'b0;
            for (int i = 0; i < 32; i++) m_reg[i] = spec_init(i);
        end else if (host_wr) begin
            if (h_mdc && !m_mdc) model_edge();
            m_mdc = h_mdc;
        end
    end

    // R5: per-cycle comparison of mdi against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            checks++;
            if (mdi !== m_mdi) begin
                errors++;
                $display("FAIL R5 cycle compare: actual %b expected %b at %0t", mdi, m_mdi, $time);
            end
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic hw(input logic c, input logic d, input logic r);
        @(negedge clk);
        host_wr = 1'b1; h_mdc = c; h_mdo = d; h_rd = r;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic tick(input logic d, input logic r);
        hw(1'b0, d, r);
        hw(1'b1, d, r);
    endtask

    task automatic preamble();
        for (int i = 0; i < 32; i++) tick(1'b1, 1'b0);
    endtask

    task automatic send(input logic [31:0] v, input int n, input logic r);
        for (int i = n - 1; i >= 0; i--) tick(v[i], r);
    endtask

    task automatic read_reg(input logic [4:0] phy, input logic [4:0] ra,
                            input logic hdr_rd, output logic [15:0] val);
        preamble();
        send({16'h0, 4'b0110, phy, ra, 2'b10}, 16, hdr_rd);
        val = '0;
        for (int k = 17; k <= 32; k++) begin
            tick(1'b1, 1'b1);
            if (k <= 31) val[31-k] = mdi;
        end
    endtask

    task automatic write_reg(input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] d);
        preamble();
        send({4'b0101, phy, ra, 2'b10, d}, 32, 1'b0);
    endtask

    logic [15:0] v;

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R8 mdi after reset", {15'h0, mdi}, 16'h0);

        // R8: reset values, bit 15 is not presented (R5)
        read_reg(5'd1, 5'd0, 1'b0, v);  chk("R8 reg0", v, 16'h3100);
        read_reg(5'd1, 5'd1, 1'b0, v);  chk("R8 reg1", v, 16'h702C);
        read_reg(5'd1, 5'd2, 1'b0, v);  chk("R8 reg2", v, 16'h7810);
        read_reg(5'd1, 5'd3, 1'b0, v);  chk("R8 reg3", v, 16'h0000);
        read_reg(5'd1, 5'd4, 1'b0, v);  chk("R8 reg4", v, 16'h0501);
        read_reg(5'd1, 5'd5, 1'b0, v);  chk("R8 reg5", v, 16'h4181);
        read_reg(5'd1, 5'd16, 1'b0, v); chk("R8 reg16", v, 16'h0003);
        read_reg(5'd1, 5'd18, 1'b0, v); chk("R8 reg18", v, 16'h0001);

        // R6: other PHY addresses read as zero
        read_reg(5'd2, 5'd1, 1'b0, v);  chk("R6 read phy2", v, 16'h0000);
        read_reg(5'd0, 5'd2, 1'b0, v);  chk("R6 read phy0", v, 16'h0000);

        // R7: masked writes
        write_reg(5'd1, 5'd4, 16'hFFFF);
        read_reg(5'd1, 5'd4, 1'b0, v);  chk("R7 reg4 mask", v, 16'h451F);
        write_reg(5'd1, 5'd0, 16'hFFFF);
        read_reg(5'd1, 5'd0, 1'b0, v);  chk("R7 reg0 locked", v, 16'h3100);
        write_reg(5'd1, 5'd1, 16'h1234);
        read_reg(5'd1, 5'd1, 1'b0, v);  chk("R7 reg1 full", v, 16'h1234);
        write_reg(5'd1, 5'd16, 16'hFFFF);
        read_reg(5'd1, 5'd16, 1'b0, v); chk("R7 reg16 mask", v, 16'h0FFF);
        write_reg(5'd1, 5'd17, 16'hFFFF);
        read_reg(5'd1, 5'd17, 1'b0, v); chk("R7 reg17 locked", v, 16'h0000);

        // R6: write to another PHY ignored
        write_reg(5'd3, 5'd1, 16'h0ABC);
        read_reg(5'd1, 5'd1, 1'b0, v);  chk("R6 write phy3 ignored", v, 16'h1234);

        // R1: repeated high and low writes between edges do nothing
        preamble();
        begin
            logic [31:0] f;
            f = {4'b0101, 5'd1, 5'd2, 2'b10, 16'h0246};
            for (int i = 31; i >= 0; i--) begin
                hw(1'b0, f[i], 1'b0);
                hw(1'b0, ~f[i], 1'b0);
                hw(1'b1, f[i], 1'b0);
                hw(1'b1, ~f[i], 1'b0);
            end
        end
        read_reg(5'd1, 5'd2, 1'b0, v);  chk("R1 non-edge writes ignored", v, 16'h0246);

        // R2 R3: header sent with read mode set, then data bit held high past edge 32
        read_reg(5'd1, 5'd2, 1'b1, v);  chk("R2 header in read mode", v, 16'h0246);
        for (int k = 33; k <= 40; k++) begin
            tick(1'b1, 1'b1);
            chk("R3 no insertion in read mode", {15'h0, mdi}, 16'h0);
        end

        // R9: unknown opcode changes nothing
        preamble();
        send({4'b0111, 5'd1, 5'd1, 2'b10, 16'h0F0F}, 32, 1'b0);
        read_reg(5'd1, 5'd1, 1'b0, v);  chk("R9 unknown opcode", v, 16'h1234);

        // R4: partial frame then preamble realigns
        send({4'b0101, 5'd1, 5'd5, 2'b10, 16'h0}, 20, 1'b0);
        read_reg(5'd1, 5'd5, 1'b0, v);  chk("R4 resync after partial", v, 16'h4181);

        // R10: saturated counter blocks an unaligned write
        preamble();
        for (int i = 0; i < 64; i++) tick(1'b0, 1'b0);
        send({4'b0101, 5'd1, 5'd1, 2'b10, 16'h0F0F}, 32, 1'b0);
        read_reg(5'd1, 5'd1, 1'b0, v);  chk("R10 saturated counter", v, 16'h1234);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule